// File: doc/BRIEF.md
# Write-Miss Line Allocation Decider

This block decides, for every write that misses the data cache, whether the cache should allocate a line for that write. A request carries an address, a read/write flag, a cache-hit flag and a sector-hit flag. The block combines them with the global cache controls, the memory-type class of the target region and two configuration values: an allocation ceiling in 4 MB steps and an enable for the 15 MB to 16 MB window. It returns a registered allocate decision one cycle later, qualified by a valid flag.

A write miss qualifies for allocation along any of three paths. The first is a hit on the page of the most recent cacheable line fill. The second is a hit on a sector that is already cached. The third is an address below the programmed ceiling. The ceiling path is blocked in the legacy hole from 640 KB to 1 MB. It is also blocked in the 15–16 MB window unless that window is enabled and the ceiling reaches 16 MB. All paths are overridden by the cache-disable controls and by uncacheable or write-combining memory types. The tracked page comes from line-fill completions reported by the fill engine.

Top module: `wr_alloc_unit`

## Requirements
- R1: A request accepted while `ctl_cache_off`, `ctl_page_nocache` or `ctl_test_inhibit` is 1 yields `dec_alloc` = 0.
- R2: A request accepted with `req_mtype` = 2 (write-combining) or 3 (uncacheable) yields `dec_alloc` = 0; types 0 (write-back) and 1 (write-through) do not veto.
- R3: A write miss with `req_addr >> 22` below `cfg_ceiling` qualifies for allocation. When `cfg_ceiling` = 0, no address qualifies through this path.
- R4: Addresses 0x000A_0000 to 0x000F_FFFF never qualify through the ceiling path; 0x0009_FFFF and 0x0010_0000 do.
- R5: A write miss that hits the tracked page (same `req_addr >> 12`), or that arrives with `req_sector_hit` = 1, allocates, including inside the 640 KB–1 MB hole and the 15–16 MB window.
- R6: Addresses 0x00F0_0000 to 0x00FF_FFFF qualify through the ceiling path only when `cfg_win_en` = 1 and `cfg_ceiling` >= 4. With a ceiling below 4, `cfg_win_en` has no effect.
- R7: The tracked page is loaded with `fill_page` (the fill address shifted right by 12) on a cycle with `fill_done` = 1. It is cleared by reset and by any cycle with `ctl_cache_off` = 1, and the clear wins over a load. A request in the same cycle as a load or clear uses the page held before that cycle.
- R8: Accepted reads and write hits produce `dec_valid` = 1 with `dec_alloc` = 0.
- R9: `req_ready` = !`dec_valid` | `dec_ready`. An accepted request shows its result on `dec_valid`/`dec_alloc` after the next clock edge. While `dec_valid` = 1 and `dec_ready` = 0, the result holds unchanged. A cycle with `dec_ready` = 1 and no accept drops `dec_valid` and `dec_alloc` to 0.
- R10: After reset, `dec_valid` = 0, `dec_alloc` = 0 and no page is tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 32 | Physical write/read address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cache_hit | input | 1 | Access hit the cache |
| req_sector_hit | input | 1 | Address falls in an already cached sector |
| req_mtype | input | 2 | Memory type: 0 WB, 1 WT, 2 WC, 3 UC |
| ctl_cache_off | input | 1 | Global cache-disable control bit |
| ctl_page_nocache | input | 1 | Page-level cache-disable signal |
| ctl_test_inhibit | input | 1 | Test cache-inhibit bit |
| cfg_ceiling | input | 7 | Allocation ceiling in 4 MB units, 0 = path off |
| cfg_win_en | input | 1 | Enable for the 15–16 MB window |
| fill_done | input | 1 | A cacheable line fill completed |
| fill_page | input | 20 | Page number (address >> 12) of that fill |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_alloc | output | 1 | Allocate a line for the request |

## Verification
The tracked-page update and the evaluation of a request can fall in the same cycle. A fill or a cache-disable clear can arrive together with a write to the page that the fill names. The bench provokes this directly: it pairs a fill of a new page with a write into that page, then repeats the write one cycle later. The first write must be judged against the old page and the second against the new one. Random traffic also mixes fills, clears and requests freely, and a bench model of the page register supplies the expected decision for every cycle.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {
    MT_WB = 2'd0,
    MT_WT = 2'd1,
    MT_WC = 2'd2,
    MT_UC = 2'd3
  } mtype_e;
endpackage

// File: rtl/wa_page_track.sv
module wa_page_track #(
  parameter int PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_page,
  input  logic [PAGE_W-1:0] look_page,
  output logic              hit
);
  logic              vld_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q  <= 1'b0;
      page_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      page_q <= load_page;
    end
  end

  assign hit = vld_q && (page_q == look_page);

  // R7: a clear leaves no tracked page
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !vld_q);
  // R7: a load without clear captures the page
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (vld_q && page_q == $past(load_page)));
endmodule

// File: rtl/wa_region_qual.sv
module wa_region_qual #(
  parameter int ADDR_W      = 32,
  parameter int LIMIT_W     = 7,
  parameter int LIMIT_SHIFT = 22
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LIMIT_W-1:0] ceiling,
  input  logic               win_en,
  output logic               qualify
);
  localparam int BLK_W = ADDR_W - LIMIT_SHIFT;
  localparam logic [ADDR_W-1:0] HOLE_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] HOLE_HI = ADDR_W'(32'h000F_FFFF);
  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(32'h00F0_0000);
  localparam logic [ADDR_W-1:0] WIN_HI  = ADDR_W'(32'h00FF_FFFF);
  localparam int unsigned WIN_MIN_BLK = 32'h0100_0000 >> LIMIT_SHIFT;

  logic below, in_hole, in_win, win_open;

  assign below    = addr[ADDR_W-1:LIMIT_SHIFT] < BLK_W'(ceiling);
  assign in_hole  = (addr >= HOLE_LO) && (addr <= HOLE_HI);
  assign in_win   = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign win_open = win_en && (ceiling >= LIMIT_W'(WIN_MIN_BLK));
  assign qualify  = below && !in_hole && !(in_win && !win_open);

  // R3: a zero ceiling never qualifies
  always_comb a_r3_zero_off: assert (!(ceiling == '0 && qualify));
endmodule

// File: rtl/wa_veto.sv
module wa_veto
  import wa_pkg::*;
(
  input  logic       cache_off,
  input  logic       page_nocache,
  input  logic       test_inhibit,
  input  mtype_e     mtype,
  output logic       veto
);
  logic type_block;
  assign type_block = (mtype == MT_UC) || (mtype == MT_WC);
  assign veto = cache_off || page_nocache || test_inhibit || type_block;
endmodule

// File: rtl/wr_alloc_unit.sv
module wr_alloc_unit
  import wa_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int LIMIT_W     = 7,
  parameter int LIMIT_SHIFT = 22
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic                          req_write,
  input  logic                          req_cache_hit,
  input  logic                          req_sector_hit,
  input  logic [1:0]                    req_mtype,
  input  logic                          ctl_cache_off,
  input  logic                          ctl_page_nocache,
  input  logic                          ctl_test_inhibit,
  input  logic [LIMIT_W-1:0]            cfg_ceiling,
  input  logic                          cfg_win_en,
  input  logic                          fill_done,
  input  logic [ADDR_W-PAGE_SHIFT-1:0]  fill_page,
  output logic                          dec_valid,
  input  logic                          dec_ready,
  output logic                          dec_alloc
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic page_hit, limit_ok, veto, write_miss, decide, accept;

  wa_page_track #(.PAGE_W(PAGE_W)) u_page (
    .clk       (clk),
    .rst       (rst),
    .clr       (ctl_cache_off),
    .load      (fill_done),
    .load_page (fill_page),
    .look_page (req_addr[ADDR_W-1:PAGE_SHIFT]),
    .hit       (page_hit)
  );

  wa_region_qual #(
    .ADDR_W      (ADDR_W),
    .LIMIT_W     (LIMIT_W),
    .LIMIT_SHIFT (LIMIT_SHIFT)
  ) u_region (
    .addr    (req_addr),
    .ceiling (cfg_ceiling),
    .win_en  (cfg_win_en),
    .qualify (limit_ok)
  );

  wa_veto u_veto (
    .cache_off    (ctl_cache_off),
    .page_nocache (ctl_page_nocache),
    .test_inhibit (ctl_test_inhibit),
    .mtype        (mtype_e'(req_mtype)),
    .veto         (veto)
  );

  assign write_miss = req_write && !req_cache_hit;
  assign decide     = write_miss && !veto && (page_hit || req_sector_hit || limit_ok);
  assign req_ready  = !dec_valid || dec_ready;
  assign accept     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_alloc <= 1'b0;
    end else if (accept) begin
      dec_valid <= 1'b1;
      dec_alloc <= decide;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
      dec_alloc <= 1'b0;
    end
  end

  // R1: control vetoes
  a_r1_ctl_veto: assert property (@(posedge clk) disable iff (rst)
    (accept && (ctl_cache_off || ctl_page_nocache || ctl_test_inhibit)) |=> (dec_valid && !dec_alloc));
  // R2: memory-type vetoes
  a_r2_type_veto: assert property (@(posedge clk) disable iff (rst)
    (accept && req_mtype[1]) |=> !dec_alloc);
  // R8: reads and write hits never allocate
  a_r8_not_miss: assert property (@(posedge clk) disable iff (rst)
    (accept && !(req_write && !req_cache_hit)) |=> (dec_valid && !dec_alloc));
  // R9: a stalled decision holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_alloc)));
  // R9: strobe only with valid
  a_r9_qual: assert property (@(posedge clk) disable iff (rst)
    dec_alloc |-> dec_valid);
endmodule

// File: tb/wr_alloc_unit_bench.sv
module wr_alloc_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready, req_write, req_cache_hit, req_sector_hit;
  logic [31:0] req_addr;
  logic [1:0]  req_mtype;
  logic ctl_cache_off, ctl_page_nocache, ctl_test_inhibit;
  logic [6:0]  cfg_ceiling;
  logic cfg_win_en, fill_done, dec_valid, dec_ready, dec_alloc;
  logic [19:0] fill_page;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  bit m_pv = 0;
  logic [19:0] m_pp = '0;
  bit m_ov = 0;
  bit m_oa = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_alloc_unit u_wr_alloc_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_cache_hit(req_cache_hit),
    .req_sector_hit(req_sector_hit), .req_mtype(req_mtype),
    .ctl_cache_off(ctl_cache_off), .ctl_page_nocache(ctl_page_nocache),
    .ctl_test_inhibit(ctl_test_inhibit), .cfg_ceiling(cfg_ceiling),
    .cfg_win_en(cfg_win_en), .fill_done(fill_done), .fill_page(fill_page),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_alloc(dec_alloc)
  );

  function automatic bit exp_alloc();
    bit veto, wm, lim, hole, win, pg;
    veto = ctl_cache_off || ctl_page_nocache || ctl_test_inhibit || req_mtype >= 2'd2;
    wm   = req_write && !req_cache_hit;
    hole = req_addr >= 32'h000A_0000 && req_addr <= 32'h000F_FFFF;
    win  = req_addr >= 32'h00F0_0000 && req_addr <= 32'h00FF_FFFF;
    lim  = ({22'd0, req_addr[31:22]} < {25'd0, cfg_ceiling}) && !hole &&
           !(win && !(cfg_win_en && cfg_ceiling >= 7'd4));
    pg   = m_pv && m_pp == req_addr[31:12];
    return wm && !veto && (pg || req_sector_hit || lim);
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_cache_hit = 0; req_sector_hit = 0;
    req_addr = '0; req_mtype = 2'd0; ctl_cache_off = 0; ctl_page_nocache = 0;
    ctl_test_inhibit = 0; fill_done = 0; fill_page = '0; dec_ready = 1;
  endtask

  // inputs already set at a negedge; run one cycle and check
  task automatic step(input string tag);
    bit rdy, acc, d;
    #1;
    rdy = !m_ov || dec_ready;
    chk(req_ready, rdy, "R9 ready");
    acc = req_valid && rdy;
    d = exp_alloc();
    @(posedge clk);
    if (acc) begin m_ov = 1; m_oa = d; end
    else if (dec_ready) begin m_ov = 0; m_oa = 0; end
    if (ctl_cache_off) m_pv = 0;
    else if (fill_done) begin m_pv = 1; m_pp = fill_page; end
    @(negedge clk);
    chk(dec_valid, m_ov, {tag, " valid"});
    chk(dec_alloc, m_oa, tag);
  endtask

  task automatic wr(input logic [31:0] a, input string tag);
    idle_inputs();
    req_valid = 1; req_write = 1; req_addr = a;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    cfg_ceiling = 0; cfg_win_en = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R10 reset state
    chk(dec_valid, 0, "R10 valid after reset");
    chk(dec_alloc, 0, "R10 alloc after reset");
    wr(32'h000A_0000, "R10 no page tracked");

    // R3 ceiling path
    cfg_ceiling = 1;
    wr(32'h003F_FFFF, "R3 below ceiling");
    wr(32'h0040_0000, "R3 at ceiling");
    cfg_ceiling = 0;
    wr(32'h0000_0000, "R3 zero ceiling");
    // R4 hole
    cfg_ceiling = 8;
    wr(32'h000A_0000, "R4 hole start");
    wr(32'h000F_FFFF, "R4 hole end");
    wr(32'h0009_FFFF, "R4 below hole");
    wr(32'h0010_0000, "R4 above hole");
    // R6 window
    wr(32'h00F0_0000, "R6 window disabled");
    wr(32'h00EF_FFFF, "R6 below window");
    cfg_win_en = 1;
    wr(32'h00FF_FFFF, "R6 window enabled");
    cfg_ceiling = 3;
    wr(32'h00F0_0000, "R6 low ceiling ignores enable");
    cfg_ceiling = 4;
    wr(32'h00F0_0000, "R6 ceiling 16MB");
    cfg_win_en = 0; cfg_ceiling = 0;
    // R7 / R5 page and sector
    idle_inputs(); fill_done = 1; fill_page = 20'h000A0; step("R7 fill idle");
    wr(32'h000A_0123, "R5 page hit in hole");
    idle_inputs(); req_valid = 1; req_write = 1; req_addr = 32'h00F8_0000;
    req_sector_hit = 1; step("R5 sector hit in window");
    idle_inputs(); req_valid = 1; req_write = 1; req_addr = 32'h000B_0000;
    fill_done = 1; fill_page = 20'h000B0; step("R7 same-cycle fill uses old page");
    wr(32'h000B_0FFF, "R7 new page next cycle");
    idle_inputs(); ctl_cache_off = 1; fill_done = 1; fill_page = 20'h000C0;
    step("R7 clear beats load");
    wr(32'h000B_0000, "R7 page cleared");
    wr(32'h000C_0000, "R7 load dropped by clear");
    // R1 control vetoes
    cfg_ceiling = 8;
    idle_inputs(); req_valid = 1; req_write = 1; ctl_cache_off = 1; step("R1 cache off");
    idle_inputs(); req_valid = 1; req_write = 1; ctl_page_nocache = 1; step("R1 page nocache");
    idle_inputs(); req_valid = 1; req_write = 1; ctl_test_inhibit = 1; step("R1 test inhibit");
    // R2 memory types
    for (int t = 0; t < 4; t++) begin
      idle_inputs(); req_valid = 1; req_write = 1; req_mtype = t[1:0]; step("R2 memory type");
    end
    // R8 reads and hits
    idle_inputs(); req_valid = 1; step("R8 read");
    idle_inputs(); req_valid = 1; req_write = 1; req_cache_hit = 1; step("R8 write hit");
    // R9 stall and hold
    idle_inputs(); dec_ready = 0; req_valid = 1; req_write = 1; step("R9 first");
    idle_inputs(); dec_ready = 0; req_valid = 1; req_write = 1; req_mtype = 2'd3; step("R9 hold");
    idle_inputs(); dec_ready = 1; req_valid = 1; req_write = 1; req_mtype = 2'd3; step("R9 release");
    idle_inputs(); step("R9 drain");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int sel;
      idle_inputs();
      req_valid = ($urandom % 8) != 0;
      req_write = ($urandom % 4) != 0;
      req_cache_hit = ($urandom % 5) == 0;
      req_sector_hit = ($urandom % 7) == 0;
      req_mtype = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      ctl_cache_off = ($urandom % 20) == 0;
      ctl_page_nocache = ($urandom % 20) == 0;
      ctl_test_inhibit = ($urandom % 20) == 0;
      fill_done = ($urandom % 6) == 0;
      fill_page = 20'h000A0 + 20'($urandom % 4);
      dec_ready = ($urandom % 4) != 0;
      if (i % 50 == 0) begin cfg_ceiling = 7'($urandom % 12); cfg_win_en = 1'($urandom); end
      sel = $urandom % 4;
      case (sel)
        0: req_addr = 32'h000A_0000 + ($urandom % 32'h0006_0000);
        1: req_addr = 32'h00F0_0000 + ($urandom % 32'h0010_0000);
        2: req_addr = {20'h000A0 + 20'($urandom % 4), 12'($urandom)};
        default: req_addr = $urandom % 32'h0300_0000;
      endcase
      if (req_mtype >= 2 || ctl_cache_off || ctl_page_nocache || ctl_test_inhibit)
        step("R1 R2 random veto");
      else if (!req_write || req_cache_hit) step("R8 random");
      else step("R3 R5 R6 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule